// File: doc/BRIEF.md
# USB Endpoint Interrupt Flag Register

This block is the interrupt and status register set of a small USB device function, as the CPU sees it on a simple byte-wide register bus. The USB engine sends one-cycle event pulses. The block latches each pulse into a sticky flag. The flags cover:

- endpoint 0 transmit done;
- endpoint 0 receive done;
- endpoint 1/2 transmit acknowledged;
- end of packet;
- resume.

Each flag has its own interrupt enable. A single level-sensitive interrupt request stays high while any enabled flag is set.

Software never clears a flag by writing the flag itself. The flags are read-only, and writes to the flag register are ignored. Each flag is cleared by writing 1 to its own write-only bit in a separate clear register. The same flag also decides how the next IN transaction on endpoints 1 and 2 is answered. Data is sent with ACK only when software has cleared that flag and set the transmit-enable bit. Otherwise the answer is NAK. A suspend bit set by software removes the USB clock-gate enable until software clears it, normally after a resume event has been serviced.

Top module: `usbirq_regs`

## Requirements
- R1: After synchronous active-low reset, all three readable registers read 0x00, irq is 0, ep12_in_ack is 0 and usb_clk_en is 1.
- R2: A one-cycle event pulse sets its flag at the next clock edge, and the flag then stays set. The flag register (address 0) shows the flags at these bits: bit 7 endpoint 1/2 transmit acknowledged, bit 6 end of packet, bit 5 resume, bit 4 endpoint 0 transmit, bit 3 endpoint 0 receive. Bits 2..0 read 0.
- R3: Writing the clear register (address 1) clears each flag whose bit, at the same position as in the flag register, is written 1. Bits written 0 leave their flags unchanged. The clear register always reads 0x00.
- R4: If an event pulse and a clear of the same flag fall in the same cycle, the flag is set after that edge.
- R5: Writes to the flag register (address 0) change no flag.
- R6: irq is 1 exactly when some flag is set and its enable is 1. The enables are in the control register (address 2): bit 6 endpoint 1/2, bit 5 end of packet, bit 4 resume, bit 3 endpoint 0 transmit, bit 2 endpoint 0 receive.
- R7: ep12_in_ack (1 = ACK with data, 0 = NAK) is 1 only while control bit 0 (transmit enable) is 1 and the endpoint 1/2 flag is 0. An endpoint 1/2 acknowledged pulse clears the transmit enable, and this wins over a software write in the same cycle.
- R8: Control bit 7 is suspend. usb_clk_en is its inverse. A resume pulse sets the resume flag but does not change suspend.
- R9: The control register reads back what was last written, with bit 1 always 0. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 flags, 1 clear, 2 control |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| ev_ep0_tx | input | 1 | Endpoint 0 transmit done pulse |
| ev_ep0_rx | input | 1 | Endpoint 0 receive done pulse |
| ev_ep12_ack | input | 1 | Endpoint 1/2 packet sent and acknowledged pulse |
| ev_eop | input | 1 | End-of-packet pulse |
| ev_resume | input | 1 | Resume detected pulse |
| irq | output | 1 | Interrupt request, level |
| ep12_in_ack | output | 1 | IN handshake select for endpoints 1/2: 1 ACK, 0 NAK |
| usb_clk_en | output | 1 | USB clock-gate enable |

## Verification
The assertions assume that the event inputs are synchronous to clk and that a write lasts a single cycle. They also assume that nothing is sampled while rst_n is low. The stimulus drives every input only at the falling edge and holds it for one full cycle. Event pulses may land in the same cycle as a clear or control write, which is how the set-wins and acknowledge-wins cases are reached. Outside those cases, the rules for flag clearing and transmit enable are each checked in isolation, alongside a long pseudo-random mix of events and writes.

// File: rtl/usbirq_pkg.sv
// Package: shared constants for the USB endpoint interrupt flag register.
// Assumes flag index i is shown at bit FLAG_LSB+i of the flag and clear
// registers and its enable at bit IEN_LSB+i of the control register.
package usbirq_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 2;
    localparam int NUM_FLAGS = 5;
    localparam int FLAG_LSB  = DATA_W - NUM_FLAGS;
    localparam int IEN_LSB   = 2;
    localparam int CTL_TXEN  = 0;
    localparam int CTL_SUSP  = DATA_W - 1;

    // flag indices; their order fixes their bit positions
    localparam int FL_EP0RX  = 0;
    localparam int FL_EP0TX  = 1;
    localparam int FL_RESUME = 2;
    localparam int FL_EOP    = 3;
    localparam int FL_EP12   = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_FLAGS = 2'd0,
        RA_CLEAR = 2'd1,
        RA_CTRL  = 2'd2,
        RA_NONE  = 2'd3
    } reg_addr_e;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;
    typedef logic [DATA_W-1:0]    byte_t;
endpackage

// File: rtl/usbirq_flag_bank.sv
// Module: bank of sticky event flags.
// Each flag sets on a one-cycle hardware pulse and clears on a software
// clear strobe; a set in the same cycle as a clear wins so no event is lost.
// Assumes set and clear inputs are synchronous to clk.
module usbirq_flag_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // hold one flag: reset, set-wins, then clear
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_o[i] <= 1'b0;
            else if (set_i[i]) flag_o[i] <= 1'b1;
            else if (clr_i[i]) flag_o[i] <= 1'b0;
        end

        p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_o[i]);
        p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
        p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[i] && !set_i[i]) |=> $stable(flag_o[i]));
    end
endmodule

// File: rtl/usbirq_ctrl_reg.sv
// Module: control register holding suspend, interrupt enables and the
// endpoint 1/2 transmit enable; also forms the IN handshake select.
// Assumes wr_i is a single-cycle write strobe already decoded for this
// register. An acknowledge pulse clears transmit enable over a write.
module usbirq_ctrl_reg
    import usbirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_i,
    input  byte_t     wdata_i,
    input  logic      ep12_ack_i,
    input  logic      ep12_flag_i,
    output byte_t     ctrl_o,
    output flag_vec_t ien_o,
    output logic      suspend_o,
    output logic      in_ack_o
);
    logic tx_en_q;
    logic unused_wbit;

    assign unused_wbit = wdata_i[1];

    // enables and suspend load on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_o     <= '0;
            suspend_o <= 1'b0;
        end else if (wr_i) begin
            ien_o     <= wdata_i[IEN_LSB +: NUM_FLAGS];
            suspend_o <= wdata_i[CTL_SUSP];
        end
    end

    // transmit enable: set by software, cleared by an acknowledged send
    always_ff @(posedge clk) begin
        if (!rst_n)          tx_en_q <= 1'b0;
        else if (ep12_ack_i) tx_en_q <= 1'b0;
        else if (wr_i)       tx_en_q <= wdata_i[CTL_TXEN];
    end

    // readback image, bit 1 is not implemented
    always_comb begin
        ctrl_o                       = '0;
        ctrl_o[CTL_SUSP]             = suspend_o;
        ctrl_o[IEN_LSB +: NUM_FLAGS] = ien_o;
        ctrl_o[CTL_TXEN]             = tx_en_q;
    end

    // ACK only when a packet is armed and the previous one was serviced
    assign in_ack_o = tx_en_q & ~ep12_flag_i;

    p_ack_drops_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ep12_ack_i |=> !in_ack_o);
    p_nak_while_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ep12_flag_i |-> !in_ack_o);
endmodule

// File: rtl/usbirq_bus_dec.sv
// Module: register bus decode and read multiplexer.
// Produces the per-flag clear strobes and the control write strobe, and
// selects read data; the clear register is write-only and reads zero.
// Assumes bus_wr lasts one cycle per write.
module usbirq_bus_dec
    import usbirq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  flag_vec_t         clr_bits_i,
    input  flag_vec_t         flags_i,
    input  byte_t             ctrl_i,
    output flag_vec_t         clr_o,
    output logic              ctrl_wr_o,
    output byte_t             rdata_o
);
    reg_addr_e sel;

    assign sel       = reg_addr_e'(addr_i);
    assign clr_o     = (wr_i && sel == RA_CLEAR) ? clr_bits_i : '0;
    assign ctrl_wr_o = wr_i && sel == RA_CTRL;

    // read multiplexer
    always_comb begin
        rdata_o = '0;
        case (sel)
            RA_FLAGS: rdata_o[FLAG_LSB +: NUM_FLAGS] = flags_i;
            RA_CTRL:  rdata_o = ctrl_i;
            default:  rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/usbirq_regs.sv
// Module: top of the USB endpoint interrupt flag register.
// Joins the flag bank, control register and bus decode; drives the level
// interrupt, the endpoint 1/2 IN handshake select and the USB clock gate.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module usbirq_regs
    import usbirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ev_ep0_tx,
    input  logic              ev_ep0_rx,
    input  logic              ev_ep12_ack,
    input  logic              ev_eop,
    input  logic              ev_resume,
    output logic              irq,
    output logic              ep12_in_ack,
    output logic              usb_clk_en
);
    flag_vec_t set_v, clr_v, flags, ien;
    byte_t     ctrl;
    logic      ctrl_wr, suspend;

    // gather event pulses in flag index order
    always_comb begin
        set_v            = '0;
        set_v[FL_EP0RX]  = ev_ep0_rx;
        set_v[FL_EP0TX]  = ev_ep0_tx;
        set_v[FL_RESUME] = ev_resume;
        set_v[FL_EOP]    = ev_eop;
        set_v[FL_EP12]   = ev_ep12_ack;
    end

    usbirq_bus_dec u_dec (
        .addr_i     (bus_addr),
        .wr_i       (bus_wr),
        .clr_bits_i (bus_wdata[FLAG_LSB +: NUM_FLAGS]),
        .flags_i    (flags),
        .ctrl_i     (ctrl),
        .clr_o      (clr_v),
        .ctrl_wr_o  (ctrl_wr),
        .rdata_o    (bus_rdata)
    );

    usbirq_flag_bank #(.N(NUM_FLAGS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_v),
        .clr_i  (clr_v),
        .flag_o (flags)
    );

    usbirq_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (ctrl_wr),
        .wdata_i     (bus_wdata),
        .ep12_ack_i  (ev_ep12_ack),
        .ep12_flag_i (flags[FL_EP12]),
        .ctrl_o      (ctrl),
        .ien_o       (ien),
        .suspend_o   (suspend),
        .in_ack_o    (ep12_in_ack)
    );

    // level interrupt from enabled flags; clock gate from suspend
    assign irq        = |(flags & ien);
    assign usb_clk_en = ~suspend;

    p_flags_ignore_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RA_FLAGS && set_v == '0) |=> $stable(flags));
    p_clear_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == RA_CLEAR) |-> (bus_rdata == '0));
    p_suspend_gates_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[CTL_SUSP] && !ev_ep12_ack) |=> !usb_clk_en);
    p_resume_keeps_susp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_resume && !ctrl_wr) |=> $stable(usb_clk_en));
    p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0));
endmodule

// File: tb/sim_usbirq_regs.sv
// Bench: behavioural reference model compared with the design every clock.
module sim_usbirq_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [4:0] ev = '0;  // 0 ep0rx,1 ep0tx,2 resume,3 eop,4 ep12 ack
    logic       irq, ep12_in_ack, usb_clk_en;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // reference state
    bit [4:0] m_flag = '0;
    bit [4:0] m_ien = '0;
    bit       m_txen = 0;
    bit       m_susp = 0;

    always #2.5 clk = ~clk;

    usbirq_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_ep0_tx(ev[1]), .ev_ep0_rx(ev[0]), .ev_ep12_ack(ev[4]),
        .ev_eop(ev[3]), .ev_resume(ev[2]),
        .irq(irq), .ep12_in_ack(ep12_in_ack), .usb_clk_en(usb_clk_en)
    );

    function automatic bit [7:0] exp_rd(input bit [1:0] a);
        case (a)
            2'd0:    return {m_flag, 3'b000};
            2'd2:    return {m_susp, m_ien, 1'b0, m_txen};
            default: return 8'h00;
        endcase
    endfunction

    task automatic compare(input string req);
        bit [7:0] er;
        bit ei, ea, ec;
        er = exp_rd(bus_addr);
        ei = |(m_flag & m_ien);
        ea = m_txen & ~m_flag[4];
        ec = ~m_susp;
        tests++;
        if (bus_rdata !== er || irq !== ei || ep12_in_ack !== ea || usb_clk_en !== ec) begin
            fails++;
            $display("FAIL %s: rd=%h irq=%b ack=%b clken=%b exp rd=%h irq=%b ack=%b clken=%b",
                     req, bus_rdata, irq, ep12_in_ack, usb_clk_en, er, ei, ea, ec);
        end
    endtask

    // one cycle: drive at falling edge, update model at rising edge, compare
    task automatic step(input bit [1:0] a, input bit w, input bit [7:0] d,
                        input bit [4:0] e, input string req);
        bus_addr = a; bus_wr = w; bus_wdata = d; ev = e;
        @(posedge clk);
        if (e[4]) m_txen = 0;
        else if (w && a == 2'd2) m_txen = d[0];
        if (w && a == 2'd2) begin
            m_ien = d[6:2];
            m_susp = d[7];
        end
        m_flag = e | (m_flag & ~((w && a == 2'd1) ? d[7:3] : 5'b0));
        @(negedge clk);
        #0.5;
        compare(req);
    endtask

    task automatic rd(input bit [1:0] a, input string req);
        step(a, 0, 8'h00, 5'b0, req);
    endtask

    initial begin
        bit [31:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of every register and output
        rd(0, "R1"); rd(1, "R1"); rd(2, "R1"); rd(3, "R1");
        // R2: each event sets its own flag, sticky
        for (int i = 0; i < 5; i++) begin
            step(0, 0, 0, 5'(1 << i), "R2");
            rd(0, "R2");
        end
        // R3: writing zeros leaves flags, ones clear selected flags
        step(1, 1, 8'h00, 5'b0, "R3"); rd(0, "R3");
        step(1, 1, 8'h28, 5'b0, "R3"); rd(0, "R3");
        rd(1, "R3");
        step(1, 1, 8'hF8, 5'b0, "R3"); rd(0, "R3");
        // R4: set and clear of same flag in one cycle, set wins
        step(1, 1, 8'h18, 5'b00011, "R4"); rd(0, "R4");
        // R5: writes to the flag register change no flag
        step(0, 1, 8'hFF, 5'b0, "R5"); rd(0, "R5");
        step(0, 1, 8'h00, 5'b0, "R5"); rd(0, "R5");
        // R9: control readback, bit 1 reads 0, address 3 reads 0
        step(2, 1, 8'hFF, 5'b0, "R9"); rd(2, "R9"); rd(3, "R9");
        step(2, 1, 8'h00, 5'b0, "R9"); rd(2, "R9");
        // R6: irq per enable
        step(1, 1, 8'hF8, 5'b0, "R6");
        step(0, 0, 0, 5'b00100, "R6");             // resume flag
        step(2, 1, 8'h08, 5'b0, "R6");              // ep0 tx enable only: no irq
        step(2, 1, 8'h10, 5'b0, "R6");              // resume enable: irq
        step(1, 1, 8'h20, 5'b0, "R6");              // clear resume: irq drops
        step(0, 0, 0, 5'b00001, "R6"); step(2, 1, 8'h04, 5'b0, "R6");
        // R7: handshake select
        step(1, 1, 8'hF8, 5'b0, "R7");
        step(2, 1, 8'h01, 5'b0, "R7");              // armed: ACK
        step(0, 0, 0, 5'b10000, "R7");              // ack: flag, tx enable off
        step(2, 1, 8'h01, 5'b0, "R7");              // re-armed, flag still set: NAK
        step(1, 1, 8'h80, 5'b0, "R7");              // cleared: ACK
        step(2, 1, 8'h41, 5'b10000, "R7");          // ack wins over write
        rd(2, "R7");
        // R8: suspend gates the clock, resume does not clear suspend
        step(2, 1, 8'h80, 5'b0, "R8");
        step(2, 0, 0, 5'b00100, "R8"); rd(0, "R8");
        step(2, 1, 8'h00, 5'b0, "R8");
        // mixed pseudo-random traffic
        lfsr = 32'hACE1_2345;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[1:0], lfsr[2] & lfsr[3], lfsr[15:8],
                 lfsr[20:16] & lfsr[25:21], "R2");
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule